// File: doc/BRIEF.md
# Link/Conditional-Store Reservation Monitor

This block sits beside a small shared word store and gives a group of cores the atomic read-modify-write primitive made of a linked load followed by a conditional store. A linked load returns the stored word and remembers, for that core, the address it read. A later conditional store from the same core commits its data and reports 1 only if no write of any kind reached that address in between. Otherwise it commits nothing and reports 0. Software builds spin locks and atomic counters by retrying until the conditional store reports 1.

Every core presents at most one request per cycle: plain load, plain store, linked load or conditional store. The address is a word index already formed by the requester. All requests of a cycle are handled as if they ran one after another in ascending core order. Each request gets its response exactly one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: A linked load (op code 2'b10) returns the word currently stored at its address and records a reservation for the issuing core on that address.
- R2: A conditional store (op code 2'b11) whose core holds a valid reservation on the same address writes its data to the store and returns 1 in bit 0 of the response data, all other bits 0.
- R3: A conditional store without a valid matching reservation returns 0 and leaves the stored word unchanged.
- R4: A committed write by any other core to a reserved address cancels that core's reservation, so its next conditional store there fails.
- R5: A plain store (op code 2'b01) by the reserving core itself to its reserved address also cancels its reservation.
- R6: Each core holds one reservation; a new linked load replaces the previous one, so a conditional store to the old address fails.
- R7: Every conditional store, passing or failing, removes the issuing core's reservation; a second one with no new linked load fails.
- R8: Requests of one cycle take effect in ascending core index: a write by a lower core cancels a higher core's reservation before that core's conditional store is judged, and when two cores write one address the higher index leaves its data.
- R9: A load (op code 2'b00) or linked load sees the data written in the same cycle by a lower-index core, and the old data when the writer has a higher index.
- R10: The response valid for a core is asserted exactly one cycle after its request; plain stores answer with data 0; after reset all responses are 0 and the store holds zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_CORES | One request strobe per core |
| req_op | input | 2*N_CORES | Per-core op code: 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr | input | AW*N_CORES | Per-core word address |
| req_wdata | input | DW*N_CORES | Per-core store data |
| rsp_valid | output | N_CORES | Response strobe, one cycle after the request |
| rsp_data | output | DW*N_CORES | Read data, or pass/fail bit for conditional stores, or 0 for stores |

## Verification
The assertions assume that each core issues at most one request per cycle with a defined op code and an address inside the store, and that requests only start once the internal reset has been released. The bench keeps to this by driving every field from a known value at the falling edge, holding valid low during reset and for several cycles after it, and drawing addresses only from the store's range. The random phase confines addresses to a handful of words so that same-cycle collisions and cross-core cancellations occur often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_serialize.sv
// Resolves all requests of one cycle in ascending core order and yields
// the next reservation state and the writes that commit.
module llsc_serialize import llsc_pkg::*; #(
  parameter int N_CORES = 4,
  parameter int AW      = 4
) (
  input  logic [N_CORES-1:0] req_valid,
  input  op_e                req_op   [N_CORES],
  input  logic [AW-1:0]      req_addr [N_CORES],
  input  logic [N_CORES-1:0] res_v_q,
  input  logic [AW-1:0]      res_a_q  [N_CORES],
  output logic [N_CORES-1:0] res_v_d,
  output logic [AW-1:0]      res_a_d  [N_CORES],
  output logic [N_CORES-1:0] wr_en,
  output logic [N_CORES-1:0] cond_ok
);
  always_comb begin
    res_v_d = res_v_q;
    res_a_d = res_a_q;
    wr_en   = '0;
    cond_ok = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (req_valid[i]) begin
        unique case (req_op[i])
          OP_LINK: begin
            res_v_d[i] = 1'b1;
            res_a_d[i] = req_addr[i];
          end
          OP_COND: begin
            cond_ok[i] = res_v_d[i] && (res_a_d[i] == req_addr[i]);
            wr_en[i]   = res_v_d[i] && (res_a_d[i] == req_addr[i]);
            res_v_d[i] = 1'b0;
          end
          OP_STORE: wr_en[i] = 1'b1;
          default: ;
        endcase
        if (wr_en[i]) begin
          for (int j = 0; j < N_CORES; j++) begin
            if (res_a_d[j] == req_addr[i]) res_v_d[j] = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/llsc_store.sv
// Shared word store with per-core read ports that forward same-cycle
// writes from lower-index cores.
module llsc_store #(
  parameter int N_CORES = 4,
  parameter int DEPTH   = 16,
  parameter int DW      = 32,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] wr_en,
  input  logic [AW-1:0]      addr    [N_CORES],
  input  logic [DW-1:0]      wdata   [N_CORES],
  output logic [DW-1:0]      rd_data [N_CORES]
);
  logic [DW-1:0] mem_q [DEPTH];

  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      rd_data[i] = mem_q[addr[i]];
      for (int j = 0; j < i; j++) begin
        if (wr_en[j] && (addr[j] == addr[i])) rd_data[i] = wdata[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      for (int i = 0; i < N_CORES; i++) begin
        if (wr_en[i]) mem_q[addr[i]] <= wdata[i];
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor import llsc_pkg::*; #(
  parameter int N_CORES = 4,
  parameter int DEPTH   = 16,
  parameter int DW      = 32,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CORES-1:0]    req_valid,
  input  logic [2*N_CORES-1:0]  req_op,
  input  logic [AW*N_CORES-1:0] req_addr,
  input  logic [DW*N_CORES-1:0] req_wdata,
  output logic [N_CORES-1:0]    rsp_valid,
  output logic [DW*N_CORES-1:0] rsp_data
);
  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  op_e                op_w    [N_CORES];
  logic [AW-1:0]      addr_w  [N_CORES];
  logic [DW-1:0]      wdata_w [N_CORES];
  logic [DW-1:0]      rd_w    [N_CORES];
  logic [N_CORES-1:0] res_v_q, res_v_d, wr_en, cond_ok;
  logic [AW-1:0]      res_a_q [N_CORES];
  logic [AW-1:0]      res_a_d [N_CORES];
  logic [DW-1:0]      rsp_d   [N_CORES];
  logic [DW-1:0]      rsp_q   [N_CORES];
  logic [N_CORES-1:0] rsp_v_q;

  for (genvar g = 0; g < N_CORES; g++) begin : g_unpack
    assign op_w[g]    = op_e'(req_op[2*g +: 2]);
    assign addr_w[g]  = req_addr[AW*g +: AW];
    assign wdata_w[g] = req_wdata[DW*g +: DW];
    assign rsp_data[DW*g +: DW] = rsp_q[g];
  end

  llsc_serialize #(.N_CORES(N_CORES), .AW(AW)) u_serial (
    .req_valid (req_valid),
    .req_op    (op_w),
    .req_addr  (addr_w),
    .res_v_q   (res_v_q),
    .res_a_q   (res_a_q),
    .res_v_d   (res_v_d),
    .res_a_d   (res_a_d),
    .wr_en     (wr_en),
    .cond_ok   (cond_ok)
  );

  llsc_store #(.N_CORES(N_CORES), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr_w),
    .wdata   (wdata_w),
    .rd_data (rd_w)
  );

  // response selection
  always_comb begin
    for (int i = 0; i < N_CORES; i++) begin
      unique case (op_w[i])
        OP_LOAD, OP_LINK: rsp_d[i] = rd_w[i];
        OP_COND:          rsp_d[i] = {{(DW-1){1'b0}}, cond_ok[i]};
        default:          rsp_d[i] = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_v_q <= '0;
      rsp_v_q <= '0;
      for (int i = 0; i < N_CORES; i++) begin
        res_a_q[i] <= '0;
        rsp_q[i]   <= '0;
      end
    end else begin
      res_v_q <= res_v_d;
      rsp_v_q <= req_valid;
      for (int i = 0; i < N_CORES; i++) begin
        if (req_valid[i]) begin
          res_a_q[i] <= res_a_d[i];
          rsp_q[i]   <= rsp_d[i];
        end
      end
    end
  end

  assign rsp_valid = rsp_v_q;

  for (genvar g = 0; g < N_CORES; g++) begin : g_chk
    // R10: response strobe follows the request by one cycle
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
      req_valid[g] |=> rsp_valid[g]);
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !req_valid[g] |=> !rsp_valid[g]);
    // R2: a pass needs a registered reservation on the same address
    a_r2_pass_needs_link: assert property (@(posedge clk) disable iff (!rst_sync_n)
      cond_ok[g] |-> (res_v_q[g] && res_a_q[g] == addr_w[g]));
    // R7: any conditional store leaves its core without a reservation
    a_r7_cond_drops_link: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (req_valid[g] && op_w[g] == OP_COND) |=> !res_v_q[g]);
    // R3: conditional store answers with a single bit
    a_r3_cond_resp_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (req_valid[g] && op_w[g] == OP_COND) |=> (rsp_q[g][DW-1:1] == '0));
    // R4: a reservation only disappears when some request was present
    a_r4_drop_needs_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(res_v_q[g]) |-> $past(|req_valid));
  end
endmodule

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int N  = 4;
  localparam int DP = 16;
  localparam int DW = 32;
  localparam int AW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    rsp_valid;
  logic [DW*N-1:0] rsp_data;

  always #2.5 clk = ~clk;

  llsc_monitor #(.N_CORES(N), .DEPTH(DP), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference state
  logic [DW-1:0] m_mem [DP];
  bit            m_v   [N];
  int            m_a   [N];
  bit            e_v   [N];
  logic [DW-1:0] e_d   [N];
  string         e_tag = "R10";

  // pending requests for the next cycle
  bit            p_v [N];
  int            p_op[N];
  int            p_a [N];
  logic [DW-1:0] p_d [N];

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(int c, int op, int a, logic [DW-1:0] d);
    p_v[c] = 1; p_op[c] = op; p_a[c] = a; p_d[c] = d;
  endtask

  // one cycle: compare last cycle's responses, then issue pending requests
  task automatic tick(string tag);
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      check(e_tag, $sformatf("core%0d valid", c), DW'(rsp_valid[c]), DW'(e_v[c]));
      if (e_v[c]) check(e_tag, $sformatf("core%0d data", c), rsp_data[DW*c +: DW], e_d[c]);
    end
    for (int c = 0; c < N; c++) begin
      req_valid[c]          = p_v[c];
      req_op[2*c +: 2]      = 2'(p_op[c]);
      req_addr[AW*c +: AW]  = AW'(p_a[c]);
      req_wdata[DW*c +: DW] = p_d[c];
      e_v[c] = p_v[c];
      e_d[c] = '0;
      if (p_v[c]) begin
        case (p_op[c])
          0: e_d[c] = m_mem[p_a[c]];
          1: begin
            m_mem[p_a[c]] = p_d[c];
            for (int k = 0; k < N; k++) if (m_a[k] == p_a[c]) m_v[k] = 0;
          end
          2: begin
            e_d[c] = m_mem[p_a[c]];
            m_v[c] = 1; m_a[c] = p_a[c];
          end
          default: begin
            bit ok;
            ok = m_v[c] && (m_a[c] == p_a[c]);
            m_v[c] = 0;
            e_d[c] = DW'(ok);
            if (ok) begin
              m_mem[p_a[c]] = p_d[c];
              for (int k = 0; k < N; k++) if (m_a[k] == p_a[c]) m_v[k] = 0;
            end
          end
        endcase
      end
      p_v[c] = 0;
    end
    e_tag = tag;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DP; k++) m_mem[k] = '0;
    for (int c = 0; c < N; c++) begin
      m_v[c] = 0; m_a[c] = 0; e_v[c] = 0; e_d[c] = '0; p_v[c] = 0;
      p_op[c] = 0; p_a[c] = 0; p_d[c] = '0;
    end
    repeat (4) @(negedge clk);
    // R10: reset state while reset is held
    check("R10", "rsp_valid in reset", DW'(rsp_valid), '0);
    check("R10", "rsp_data in reset", rsp_data[DW-1:0], '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10", "rsp_valid after reset", DW'(rsp_valid), '0);
    // R10: store starts at zero
    put(1, 0, 9, '0); tick("R10");
    tick("R10");
    // R1: linked load returns stored word
    put(0, 1, 3, 32'h55); tick("R10");
    put(0, 2, 3, '0); tick("R1");
    // R2: matching conditional store passes, then visible
    put(0, 3, 3, 32'h77); tick("R2");
    put(1, 0, 3, '0); tick("R2");
    // R7: second conditional store fails
    put(0, 3, 3, 32'h99); tick("R7");
    put(1, 0, 3, '0); tick("R3");
    // R4: other core's write cancels
    put(1, 2, 5, '0); tick("R1");
    put(2, 1, 5, 32'hAB); tick("R10");
    put(1, 3, 5, 32'hCD); tick("R4");
    put(3, 0, 5, '0); tick("R3");
    // R5: own store cancels
    put(2, 2, 6, '0); tick("R1");
    put(2, 1, 6, 32'h11); tick("R10");
    put(2, 3, 6, 32'h22); tick("R5");
    put(2, 0, 6, '0); tick("R5");
    // R6: newer link replaces older
    put(3, 2, 7, '0); tick("R1");
    put(3, 2, 8, '0); tick("R1");
    put(3, 3, 7, 32'h33); tick("R6");
    put(3, 2, 8, '0); tick("R1");
    put(3, 3, 8, 32'h44); tick("R6");
    // R8: lower-index store kills higher-index link before its check
    put(1, 2, 9, '0); put(2, 2, 9, '0); tick("R1");
    put(1, 1, 9, 32'h5); put(2, 3, 9, 32'h6); tick("R8");
    // R8: lower-index pass kills higher-index link in the same cycle
    put(0, 2, 10, '0); put(3, 2, 10, '0); tick("R1");
    put(0, 3, 10, 32'hA0); put(3, 3, 10, 32'hA3); tick("R8");
    put(1, 0, 10, '0); tick("R8");
    // R8: higher-index writer's data remains
    put(0, 1, 11, 32'hB0); put(2, 1, 11, 32'hB2); tick("R8");
    put(3, 0, 11, '0); tick("R8");
    // R9: forwarding only from lower index
    put(0, 1, 12, 32'hC0); put(1, 0, 12, '0); tick("R9");
    put(1, 1, 13, 32'hD1); put(0, 0, 13, '0); tick("R9");
    put(2, 0, 13, '0); tick("R9");
    // R8: random traffic on a few words
    for (int n = 0; n < 600; n++) begin
      for (int c = 0; c < N; c++) begin
        if ($urandom_range(0, 2) != 0)
          put(c, $urandom_range(0, 3), $urandom_range(0, 3), $urandom());
      end
      tick("R8");
    end
    tick("R8");
    tick("R10");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule